// File: doc/BRIEF.md
# Cascadable I2C LCD Segment Driver

This block is a write-only I2C target that holds the segment data for one slice of a static or duplex LCD. Eight byte-wide segment registers sit in two banks: the even-numbered registers form bank A and the odd-numbered ones form bank B. A host writes an address byte, a control byte and then any number of segment bytes. The control byte sets the drive mode and the bank, and it loads a 6-bit pointer. The upper three pointer bits name a chip and the lower three name a register. Up to eight copies share the same bus address and are told apart only by their three hardware address pins. The pointer steps forward in every copy after each data byte, so a long write moves from one chip to the next and the group behaves as one 256-segment display.

The bus lines are sampled by the local clock through a synchronizer. The block acknowledges by asserting `sda_pull`, which the pad turns into an open-drain low on SDA. Two display planes present the stored bytes as backplane data. In static mode plane A carries the chosen bank and plane B is zero. In duplex mode plane A carries bank A and plane B carries bank B.

The byte sequencer has eight states. `ST_IDLE` waits for a start. `ST_ADDR` shifts in the address byte and then moves to `ST_ADDR_ACK` on a match or to `ST_IGNORE` on a mismatch. `ST_ADDR_ACK` moves to `ST_CTRL` on the next SCL fall. `ST_CTRL` commits the control byte and moves to `ST_CTRL_ACK`, which moves to `ST_DATA`. `ST_DATA` commits a segment byte and moves to `ST_DATA_ACK`, which returns to `ST_DATA`. From any state a start goes to `ST_ADDR` and a stop goes to `ST_IDLE`.

Top module: `lcdseg_i2c_driver`

## Requirements
- R1: After reset every segment register is zero, the mode is static (0), bank A (0) is selected, both planes are zero and `sda_pull` is low.
- R2: Bytes are taken MSB first on SCL rising edges. An address byte equal to 0x74 (target address 0111010 followed by a write bit of 0) is acknowledged by every chip. The acknowledge is only raised or dropped while SCL is low.
- R3: An address byte with a different address, or with the R/W bit set (0x75), gets no acknowledge from any chip. Every byte after it is then ignored until the next start, and the outputs stay unchanged.
- R4: The second byte is the control byte: bit 7 is the drive mode (1 = duplex), bit 6 is the bank (1 = bank B) and bits 5..0 load the pointer. Every addressed chip acknowledges it. Mode and bank take effect at the end of that byte.
- R5: A segment byte is stored in register pointer[2:0] only by a chip whose pins equal pointer[5:3] in static mode, or whose pins [1:0] equal pointer[4:3] in duplex mode. Only such chips acknowledge that byte.
- R6: After each segment byte the pointer advances in every addressed chip, selected or not, by 2 in static mode and by 1 in duplex mode, modulo 64.
- R7: A stop placed right after the control byte's acknowledge changes only the mode and bank, and leaves the segment registers untouched.
- R8: A start or repeated start at any point makes the next byte an address byte again.
- R9: In static mode plane A byte i shows register 2i+bank and plane B is zero. In duplex mode plane A byte i shows register 2i and plane B byte i shows register 2i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | I2C clock line as seen at the pad |
| sda_in | input | 1 | I2C data line as seen at the pad |
| hw_addr | input | 3 | Hardware address pins of this chip |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |
| seg_regs | output | 64 | Segment registers, register n in bits 8n+7..8n |
| drive_mode | output | 1 | 0 static, 1 duplex |
| bank_sel | output | 1 | 0 bank A, 1 bank B |
| plane_a | output | 32 | Segment data for backplane 1 |
| plane_b | output | 32 | Segment data for backplane 2 |

## Verification
The assertions assume that SCL stays low for several local clocks around each acknowledge edge. They also assume that SDA changes only while SCL is low, except for start and stop conditions, and that the host never issues a stop or start while a chip is acknowledging. The bench's bus master holds every SCL phase for eight or more clocks. It changes SDA only in the middle of the low phase, and it releases SDA during every acknowledge slot. All eight chips share one wired-AND SDA net, so each acknowledge mask and each cross-chip pointer hand-off is observed just as the bus would see it.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;

    localparam logic [6:0] LCDSEG_TARGET_ADDR = 7'b0111010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } bus_state_t;

endpackage

// File: rtl/lcdseg_bus_sense.sv
module lcdseg_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_cond,
    output logic stop_cond
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_s;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s      = scl_pipe[SYNC_STAGES-1];
    assign sda_s      = sda_pipe[SYNC_STAGES-1];
    assign scl_rise   = scl_s & ~scl_q;
    assign scl_fall   = ~scl_s & scl_q;
    assign start_cond = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_cond  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/lcdseg_byte_fsm.sv
module lcdseg_byte_fsm
    import lcdseg_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter logic [6:0] TARGET_ADDR = LCDSEG_TARGET_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_cond,
    input  logic              stop_cond,
    input  logic              sel_hit,
    output logic [DATA_W-1:0] rx_byte,
    output logic              ctrl_commit,
    output logic              data_commit,
    output logic              sda_pull
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    bus_state_t        state;
    bus_state_t        state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  bit_cnt_n;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shreg_n;
    logic              byte_full;
    logic              addr_ok;
    logic              in_ack;

    assign byte_full = (bit_cnt == CNT_W'(DATA_W));
    assign addr_ok   = (shreg == {TARGET_ADDR, 1'b0});
    assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_CTRL_ACK) ||
                       (state == ST_DATA_ACK);
    assign rx_byte   = shreg;

    always_comb begin
        state_n     = state;
        bit_cnt_n   = bit_cnt;
        shreg_n     = shreg;
        ctrl_commit = 1'b0;
        data_commit = 1'b0;
        if (start_cond) begin
            state_n   = ST_ADDR;
            bit_cnt_n = '0;
        end else if (stop_cond) begin
            state_n   = ST_IDLE;
            bit_cnt_n = '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: begin
                    state_n = state;
                end
                ST_ADDR, ST_CTRL, ST_DATA: begin
                    if (scl_rise && !byte_full) begin
                        shreg_n   = {shreg[DATA_W-2:0], sda_s};
                        bit_cnt_n = bit_cnt + 1'b1;
                    end else if (scl_fall && byte_full) begin
                        bit_cnt_n = '0;
                        if (state == ST_ADDR) begin
                            state_n = addr_ok ? ST_ADDR_ACK : ST_IGNORE;
                        end else if (state == ST_CTRL) begin
                            state_n     = ST_CTRL_ACK;
                            ctrl_commit = 1'b1;
                        end else begin
                            state_n     = ST_DATA_ACK;
                            data_commit = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_n = ST_CTRL;
                end
                ST_CTRL_ACK, ST_DATA_ACK: begin
                    if (scl_fall) state_n = ST_DATA;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            state   <= state_n;
            bit_cnt <= bit_cnt_n;
            shreg   <= shreg_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
        end else if (start_cond || stop_cond) begin
            sda_pull <= 1'b0;
        end else if (state == ST_ADDR && state_n == ST_ADDR_ACK) begin
            sda_pull <= 1'b1;
        end else if (ctrl_commit) begin
            sda_pull <= 1'b1;
        end else if (data_commit) begin
            sda_pull <= sel_hit;
        end else if (in_ack && scl_fall) begin
            sda_pull <= 1'b0;
        end
    end

endmodule

// File: rtl/lcdseg_seg_store.sv
module lcdseg_seg_store #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 8,
    parameter int HW_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [HW_W-1:0]            hw_addr,
    input  logic                       ctrl_commit,
    input  logic                       data_commit,
    input  logic [DATA_W-1:0]          rx_byte,
    output logic                       sel_hit,
    output logic                       drive_mode,
    output logic                       bank_sel,
    output logic [NUM_REGS*DATA_W-1:0] seg_flat
);

    localparam int REG_AW = $clog2(NUM_REGS);
    localparam int VEC_W  = REG_AW + HW_W;

    logic [VEC_W-1:0] vec;
    logic             hit_static;
    logic             hit_duplex;
    logic [VEC_W-1:0] vec_step;

    assign hit_static = (vec[VEC_W-1:REG_AW] == hw_addr);
    assign hit_duplex = (vec[VEC_W-2:REG_AW] == hw_addr[HW_W-2:0]);
    assign sel_hit    = drive_mode ? hit_duplex : hit_static;
    assign vec_step   = drive_mode ? VEC_W'(1) : VEC_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec        <= '0;
            drive_mode <= 1'b0;
            bank_sel   <= 1'b0;
        end else if (ctrl_commit) begin
            drive_mode <= rx_byte[DATA_W-1];
            bank_sel   <= rx_byte[DATA_W-2];
            vec        <= rx_byte[VEC_W-1:0];
        end else if (data_commit) begin
            vec <= vec + vec_step;
        end
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_flat[r*DATA_W +: DATA_W] <= '0;
            end else if (data_commit && sel_hit &&
                         vec[REG_AW-1:0] == REG_AW'(r)) begin
                seg_flat[r*DATA_W +: DATA_W] <= rx_byte;
            end
        end
    end

endmodule

// File: rtl/lcdseg_plane_mux.sv
module lcdseg_plane_mux #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 8
) (
    input  logic [NUM_REGS*DATA_W-1:0]     seg_flat,
    input  logic                           drive_mode,
    input  logic                           bank_sel,
    output logic [NUM_REGS/2*DATA_W-1:0]   plane_a,
    output logic [NUM_REGS/2*DATA_W-1:0]   plane_b
);

    for (genvar i = 0; i < NUM_REGS / 2; i++) begin : g_pair
        logic [DATA_W-1:0] even_b;
        logic [DATA_W-1:0] odd_b;
        assign even_b = seg_flat[(2*i)*DATA_W +: DATA_W];
        assign odd_b  = seg_flat[(2*i+1)*DATA_W +: DATA_W];
        always_comb begin
            if (drive_mode) begin
                plane_a[i*DATA_W +: DATA_W] = even_b;
                plane_b[i*DATA_W +: DATA_W] = odd_b;
            end else begin
                plane_a[i*DATA_W +: DATA_W] = bank_sel ? odd_b : even_b;
                plane_b[i*DATA_W +: DATA_W] = '0;
            end
        end
    end

endmodule

// File: rtl/lcdseg_i2c_driver.sv
module lcdseg_i2c_driver
    import lcdseg_pkg::*;
#(
    parameter int         DATA_W      = 8,
    parameter int         NUM_REGS    = 8,
    parameter int         HW_W        = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] TARGET_ADDR = LCDSEG_TARGET_ADDR
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_in,
    input  logic                         sda_in,
    input  logic [HW_W-1:0]              hw_addr,
    output logic                         sda_pull,
    output logic [NUM_REGS*DATA_W-1:0]   seg_regs,
    output logic                         drive_mode,
    output logic                         bank_sel,
    output logic [NUM_REGS/2*DATA_W-1:0] plane_a,
    output logic [NUM_REGS/2*DATA_W-1:0] plane_b
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_cond;
    logic              stop_cond;
    logic              sel_hit;
    logic              ctrl_commit;
    logic              data_commit;
    logic [DATA_W-1:0] rx_byte;

    lcdseg_bus_sense #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_cond (start_cond),
        .stop_cond  (stop_cond)
    );

    lcdseg_byte_fsm #(
        .DATA_W     (DATA_W),
        .TARGET_ADDR(TARGET_ADDR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_cond  (start_cond),
        .stop_cond   (stop_cond),
        .sel_hit     (sel_hit),
        .rx_byte     (rx_byte),
        .ctrl_commit (ctrl_commit),
        .data_commit (data_commit),
        .sda_pull    (sda_pull)
    );

    lcdseg_seg_store #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS),
        .HW_W    (HW_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_addr     (hw_addr),
        .ctrl_commit (ctrl_commit),
        .data_commit (data_commit),
        .rx_byte     (rx_byte),
        .sel_hit     (sel_hit),
        .drive_mode  (drive_mode),
        .bank_sel    (bank_sel),
        .seg_flat    (seg_regs)
    );

    lcdseg_plane_mux #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS)
    ) u_mux (
        .seg_flat   (seg_regs),
        .drive_mode (drive_mode),
        .bank_sel   (bank_sel),
        .plane_a    (plane_a),
        .plane_b    (plane_b)
    );

endmodule

// File: rtl/lcdseg_i2c_driver_chk.sv
module lcdseg_i2c_driver_chk
    import lcdseg_pkg::*;
#(
    parameter int VEC_W  = 6,
    parameter int REGS_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_in,
    input logic              sda_pull,
    input logic              drive_mode,
    input logic              bank_sel,
    input logic [REGS_W-1:0] seg_regs,
    input bus_state_t        fsm_state,
    input logic              ctrl_commit,
    input logic              data_commit,
    input logic              sel_hit,
    input logic [VEC_W-1:0]  vec
);

    p_pull_on_low_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_in);

    p_silent_when_ignoring_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IGNORE || fsm_state == ST_IDLE) |-> !sda_pull);

    p_mode_bank_from_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({drive_mode, bank_sel}) |-> $past(ctrl_commit));

    p_store_only_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seg_regs) |-> $past(data_commit && sel_hit));

    p_no_ack_unselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_commit && !sel_hit) |=> !sda_pull);

    p_vec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_commit |=> (vec == VEC_W'($past(vec) + ($past(drive_mode) ? 1 : 2))));

    p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_commit && !ctrl_commit) |=> $stable(vec));

endmodule

bind lcdseg_i2c_driver lcdseg_i2c_driver_chk #(
    .VEC_W (HW_W + $clog2(NUM_REGS)),
    .REGS_W(NUM_REGS * DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_in),
    .sda_pull    (sda_pull),
    .drive_mode  (drive_mode),
    .bank_sel    (bank_sel),
    .seg_regs    (seg_regs),
    .fsm_state   (u_fsm.state),
    .ctrl_commit (ctrl_commit),
    .data_commit (data_commit),
    .sel_hit     (sel_hit),
    .vec         (u_store.vec)
);

// File: tb/test_lcdseg_i2c_driver.sv
module test_lcdseg_i2c_driver;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int CHIPS      = 8;
    localparam int WATCHDOG   = 150000;
    localparam logic [7:0] ADDR_W = 8'h74;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic             rst_n;
    logic             scl_drv;
    logic             sda_drv;
    logic [CHIPS-1:0] pulls;
    logic [63:0]      regs_o [CHIPS];
    logic [31:0]      pa_o   [CHIPS];
    logic [31:0]      pb_o   [CHIPS];
    logic [CHIPS-1:0] mode_o;
    logic [CHIPS-1:0] bank_o;
    wire              sda_bus = sda_drv & ~(|pulls);

    for (genvar k = 0; k < CHIPS; k++) begin : g_chip
        lcdseg_i2c_driver i_lcdseg_i2c_driver (
            .clk        (clk),
            .rst_n      (rst_n),
            .scl_in     (scl_drv),
            .sda_in     (sda_bus),
            .hw_addr    (3'(k)),
            .sda_pull   (pulls[k]),
            .seg_regs   (regs_o[k]),
            .drive_mode (mode_o[k]),
            .bank_sel   (bank_o[k]),
            .plane_a    (pa_o[k]),
            .plane_b    (pb_o[k])
        );
    end

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0] m_reg [CHIPS][8];
    logic       m_mode;
    logic       m_bank;
    logic [5:0] m_vec;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit m_sel(input int k, input logic [5:0] v, input logic md);
        if (md) return v[4:3] == 2'(k);
        return v[5:3] == 3'(k);
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < CHIPS; k++) begin
            logic [63:0] er;
            logic [31:0] ea;
            logic [31:0] eb;
            for (int r = 0; r < 8; r++) er[r*8 +: 8] = m_reg[k][r];
            for (int i = 0; i < 4; i++) begin
                if (m_mode) begin
                    ea[i*8 +: 8] = m_reg[k][2*i];
                    eb[i*8 +: 8] = m_reg[k][2*i+1];
                end else begin
                    ea[i*8 +: 8] = m_reg[k][2*i + int'(m_bank)];
                    eb[i*8 +: 8] = 8'h00;
                end
            end
            chk(req, $sformatf("chip%0d regs", k), regs_o[k], er);
            chk(req, $sformatf("chip%0d mode/bank", k),
                64'({mode_o[k], bank_o[k]}), 64'({m_mode, m_bank}));
            chk("R9", $sformatf("chip%0d plane_a", k), 64'(pa_o[k]), 64'(ea));
            chk("R9", $sformatf("chip%0d plane_b", k), 64'(pb_o[k]), 64'(eb));
        end
    endtask

    task automatic i2c_start();
        scl_drv = 1'b0; wt(Q);
        sda_drv = 1'b1; wt(Q);
        scl_drv = 1'b1; wt(Q);
        sda_drv = 1'b0; wt(Q);
        scl_drv = 1'b0; wt(Q);
    endtask

    task automatic i2c_stop();
        scl_drv = 1'b0;
        sda_drv = 1'b0; wt(Q);
        scl_drv = 1'b1; wt(Q);
        sda_drv = 1'b1; wt(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [CHIPS-1:0] exp_mask,
                             input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wt(Q);
            scl_drv = 1'b1; wt(2 * Q);
            scl_drv = 1'b0; wt(Q);
        end
        sda_drv = 1'b1; wt(Q);
        scl_drv = 1'b1; wt(Q);
        chk(req, $sformatf("ack mask byte %h", b), 64'(pulls), 64'(exp_mask));
        wt(Q);
        scl_drv = 1'b0; wt(Q);
    endtask

    task automatic ctrl_byte(input logic [7:0] c);
        send_byte(c, '1, "R4");
        m_mode = c[7];
        m_bank = c[6];
        m_vec  = c[5:0];
    endtask

    task automatic data_byte(input logic [7:0] b, input string req);
        logic [CHIPS-1:0] mask;
        for (int k = 0; k < CHIPS; k++) mask[k] = m_sel(k, m_vec, m_mode);
        send_byte(b, mask, req);
        for (int k = 0; k < CHIPS; k++)
            if (mask[k]) m_reg[k][m_vec[2:0]] = b;
        m_vec = m_vec + (m_mode ? 6'd1 : 6'd2);
    endtask

    initial begin
        for (int k = 0; k < CHIPS; k++)
            for (int r = 0; r < 8; r++) m_reg[k][r] = 8'h00;
        m_mode  = 1'b0;
        m_bank  = 1'b0;
        m_vec   = 6'd0;
        rst_n   = 1'b0;
        scl_drv = 1'b1;
        sda_drv = 1'b1;
        wt(5);
        // R1: state held in reset
        check_all("R1");
        chk("R1", "pulls in reset", 64'(pulls), 64'h0);
        rst_n = 1'b1;
        wt(5);
        chk("R1", "pulls after reset", 64'(pulls), 64'h0);

        // R2 R5 R6: static bank A, pointer from 0 across all chips
        i2c_start();
        send_byte(ADDR_W, '1, "R2");
        ctrl_byte(8'h00);
        for (int i = 0; i < 32; i++) data_byte(8'(i * 29 + 3), "R5 R6 static");
        i2c_stop();
        check_all("R5");

        // R6: static bank B from odd pointer, wraps past 63
        i2c_start();
        send_byte(ADDR_W, '1, "R2");
        ctrl_byte(8'h41);
        for (int i = 0; i < 35; i++) data_byte(8'(i * 53 + 17), "R6 wrap");
        i2c_stop();
        check_all("R6");

        // R3: wrong address, then read bit set
        i2c_start();
        send_byte(8'h76, '0, "R3 bad address");
        send_byte(8'h00, '0, "R3 after bad address");
        send_byte(8'hFF, '0, "R3 after bad address");
        i2c_stop();
        check_all("R3");
        i2c_start();
        send_byte(8'h75, '0, "R3 read bit");
        send_byte(8'h80, '0, "R3 after read bit");
        send_byte(8'h5A, '0, "R3 after read bit");
        i2c_stop();
        check_all("R3");

        // R7: stop right after control byte flips bank only
        i2c_start();
        send_byte(ADDR_W, '1, "R2");
        ctrl_byte(8'h00);
        i2c_stop();
        check_all("R7");

        // R5 duplex: pointer bit 5 set, chips k and k+4 both selected
        i2c_start();
        send_byte(ADDR_W, '1, "R2");
        ctrl_byte(8'hA0);
        for (int i = 0; i < 40; i++) data_byte(8'(i * 71 + 5), "R5 R6 duplex");
        i2c_stop();
        check_all("R5");

        // R8: repeated starts restart the byte sequence
        i2c_start();
        send_byte(ADDR_W, '1, "R2");
        ctrl_byte(8'h86);
        data_byte(8'hC3, "R5");
        data_byte(8'h3C, "R5");
        i2c_start();
        send_byte(8'h76, '0, "R8 address after restart");
        send_byte(8'h11, '0, "R8 ignored");
        i2c_start();
        send_byte(ADDR_W, '1, "R8 address after restart");
        ctrl_byte(8'h4C);
        data_byte(8'hE1, "R8");
        data_byte(8'h1E, "R8");
        data_byte(8'h99, "R8");
        i2c_stop();
        check_all("R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog run hung actual=%0d expected<%0d cycles", WATCHDOG, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule